// File: doc/BRIEF.md
# CAN Receive Acceptance Mask Selector

This block decides whether one received CAN identifier passes one receive filter. For each compare it first chooses the mask that belongs to that filter. The mask can be a shared global mask, a dedicated mask tied to a fixed buffer or FIFO table slot, or, when per-filter masking is switched on, the filter's own individual mask. It then makes a bitwise masked comparison between the received identifier and the filter identifier. A surrounding receive engine gives it one filter per strobe and collects a registered accept bit one cycle later.

Identifiers are 29 bits wide. An 11-bit standard identifier sits in bits [28:18]. All mask registers can be changed only while the block is frozen. A write made at any other time is dropped.

Top module: `can_rx_mask_select`

## Requirements
- R1: After reset, `accept_o` and `accept_vld_o` are low and every mask register is zero.
- R2: With `fifo_mode_i` = 0 and `indiv_en_i` = 0, a buffer filter at index 14 uses dedicated mask A (write select 1) and index 15 uses dedicated mask B (select 2). Every other index uses the global mask (select 0).
- R3: With `fifo_mode_i` = 1 and `indiv_en_i` = 0, table entry 6 uses FIFO mask A (select 3) and entry 7 uses FIFO mask B (select 4). Every other entry, including 14 and 15, uses the global mask.
- R4: With `indiv_en_i` = 1, filter k uses individual mask k (select 16+k) in both modes. The global and dedicated masks then have no effect.
- R5: A mask bit of 1 requires the received bit to equal the filter bit. A mask bit of 0 makes that bit a don't-care. The filter accepts only when every required bit matches.
- R6: A mask of all zeros accepts any identifier, provided the extended flags agree.
- R7: `rx_ext_i` must equal `flt_ext_i` for acceptance, whatever the mask.
- R8: When the received frame is standard (`rx_ext_i` = 0), only bits [28:18] are compared. Bits [17:0] are ignored.
- R9: A mask write (`mask_wr_i` = 1) is applied only when `frozen_i` = 1. Otherwise it has no effect.
- R10: `accept_vld_o` is high exactly in the cycle after `cmp_valid_i` is high. `accept_o` is low whenever `accept_vld_o` is low.
- R11: A compare issued in the same cycle as a mask write uses the mask value from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frozen_i | input | 1 | Block frozen; enables mask writes |
| mask_wr_i | input | 1 | Mask write strobe |
| mask_sel_i | input | 5 | Mask select: 0 global, 1/2 buffer dedicated, 3/4 FIFO dedicated, 16+k individual k |
| mask_wdata_i | input | 29 | Mask write data |
| cmp_valid_i | input | 1 | Compare strobe |
| rx_id_i | input | 29 | Received identifier |
| rx_ext_i | input | 1 | Received frame is extended |
| flt_id_i | input | 29 | Filter identifier |
| flt_ext_i | input | 1 | Filter expects extended frame |
| flt_idx_i | input | 4 | Filter index (buffer or table entry) |
| fifo_mode_i | input | 1 | Filter is a FIFO table entry |
| indiv_en_i | input | 1 | Per-filter individual masks enabled |
| accept_o | output | 1 | Registered accept result |
| accept_vld_o | output | 1 | Result valid, one cycle after strobe |

## Verification
A mask write and a compare can fall in the same cycle. The bench provokes this with directed cases that write a new value into the mask the compare selects. It also lets the random loop issue writes and compares together, both frozen and unfrozen. Each result is judged against a bench mask model that is updated only after the expected value has been computed, so it must reflect the old mask. A write that was dropped while unfrozen must leave later results unchanged.

// File: rtl/can_rx_mask_select.sv
module can_rx_mask_select #(
  parameter int ID_W       = 29,
  parameter int STD_W      = 11,
  parameter int NUM_FLT    = 16,
  parameter int DED_BUF_A  = 14,
  parameter int DED_BUF_B  = 15,
  parameter int DED_FIFO_A = 6,
  parameter int DED_FIFO_B = 7,
  localparam int IDX_W     = $clog2(NUM_FLT),
  localparam int SEL_W     = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frozen_i,
  input  logic             mask_wr_i,
  input  logic [SEL_W-1:0] mask_sel_i,
  input  logic [ID_W-1:0]  mask_wdata_i,
  input  logic             cmp_valid_i,
  input  logic [ID_W-1:0]  rx_id_i,
  input  logic             rx_ext_i,
  input  logic [ID_W-1:0]  flt_id_i,
  input  logic             flt_ext_i,
  input  logic [IDX_W-1:0] flt_idx_i,
  input  logic             fifo_mode_i,
  input  logic             indiv_en_i,
  output logic             accept_o,
  output logic             accept_vld_o
);

  localparam logic [SEL_W-1:0] SEL_GLB = SEL_W'(0);
  localparam logic [SEL_W-1:0] SEL_BA  = SEL_W'(1);
  localparam logic [SEL_W-1:0] SEL_BB  = SEL_W'(2);
  localparam logic [SEL_W-1:0] SEL_FA  = SEL_W'(3);
  localparam logic [SEL_W-1:0] SEL_FB  = SEL_W'(4);
  localparam logic [ID_W-1:0]  STD_KEEP = {{STD_W{1'b1}}, {(ID_W-STD_W){1'b0}}};

  logic [ID_W-1:0] glb_q, ba_q, bb_q, fa_q, fb_q;
  logic [ID_W-1:0] ind_q [NUM_FLT];
  logic [ID_W-1:0] sel_mask, eff_mask;
  logic            wr_ok, hit;

  assign wr_ok = mask_wr_i & frozen_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glb_q <= '0;
      ba_q  <= '0;
      bb_q  <= '0;
      fa_q  <= '0;
      fb_q  <= '0;
    end else if (wr_ok && !mask_sel_i[SEL_W-1]) begin
      case (mask_sel_i)
        SEL_GLB: glb_q <= mask_wdata_i;
        SEL_BA:  ba_q  <= mask_wdata_i;
        SEL_BB:  bb_q  <= mask_wdata_i;
        SEL_FA:  fa_q  <= mask_wdata_i;
        SEL_FB:  fb_q  <= mask_wdata_i;
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < NUM_FLT; g++) begin : g_ind
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        ind_q[g] <= '0;
      else if (wr_ok && mask_sel_i[SEL_W-1] && mask_sel_i[IDX_W-1:0] == IDX_W'(g))
        ind_q[g] <= mask_wdata_i;
    end
  end

  always_comb begin
    sel_mask = glb_q;
    if (indiv_en_i) begin
      sel_mask = ind_q[flt_idx_i];
    end else if (fifo_mode_i) begin
      if (flt_idx_i == IDX_W'(DED_FIFO_A))      sel_mask = fa_q;
      else if (flt_idx_i == IDX_W'(DED_FIFO_B)) sel_mask = fb_q;
    end else begin
      if (flt_idx_i == IDX_W'(DED_BUF_A))       sel_mask = ba_q;
      else if (flt_idx_i == IDX_W'(DED_BUF_B))  sel_mask = bb_q;
    end
  end

  assign eff_mask = rx_ext_i ? sel_mask : (sel_mask & STD_KEEP);
  assign hit      = (rx_ext_i == flt_ext_i) && (((rx_id_i ^ flt_id_i) & eff_mask) == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      accept_o     <= 1'b0;
      accept_vld_o <= 1'b0;
    end else begin
      accept_vld_o <= cmp_valid_i;
      accept_o     <= cmp_valid_i & hit;
    end
  end

  AST_VLD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid_i |=> accept_vld_o) else $error("valid timing");  // R10
  AST_EXT_MISMATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid_i && rx_ext_i != flt_ext_i) |=> !accept_o) else $error("ext flag");  // R7
  AST_ZERO_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid_i && sel_mask == '0 && rx_ext_i == flt_ext_i) |=> accept_o) else $error("zero mask");  // R6
  AST_STD_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid_i && !rx_ext_i && !flt_ext_i && rx_id_i[ID_W-1 -: STD_W] == flt_id_i[ID_W-1 -: STD_W])
    |=> accept_o) else $error("std id");  // R8
  AST_NO_WR_UNFROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_wr_i && !frozen_i) |=> $stable(glb_q)) else $error("unfrozen write");  // R9
  AST_ACC_NEEDS_VLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_valid_i |=> !accept_o) else $error("stray accept");  // R10

endmodule

// File: tb/tb_can_rx_mask_select.sv
`timescale 1ns/1ps
module tb_can_rx_mask_select;
  logic clk = 1'b0, rst_n = 1'b0;
  logic frozen_i = 0, mask_wr_i = 0, cmp_valid_i = 0;
  logic [4:0]  mask_sel_i = '0;
  logic [28:0] mask_wdata_i = '0, rx_id_i = '0, flt_id_i = '0;
  logic rx_ext_i = 0, flt_ext_i = 0, fifo_mode_i = 0, indiv_en_i = 0;
  logic [3:0] flt_idx_i = '0;
  logic accept_o, accept_vld_o;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  logic [28:0] m_glb = '0, m_ba = '0, m_bb = '0, m_fa = '0, m_fb = '0;
  logic [28:0] m_ind [16];

  always #2.5 clk = ~clk;

  can_rx_mask_select dut (.*);

  task automatic check(string req, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  function automatic logic exp_acc(logic [28:0] rx, logic rxe, logic [28:0] flt, logic fe,
                                   logic [3:0] idx, logic fifo, logic ind);
    logic [28:0] m;
    m = m_glb;
    if (ind) m = m_ind[idx];
    else if (fifo) begin
      if (idx == 4'd6) m = m_fa;
      else if (idx == 4'd7) m = m_fb;
    end else begin
      if (idx == 4'd14) m = m_ba;
      else if (idx == 4'd15) m = m_bb;
    end
    if (!rxe) m[17:0] = '0;
    return (rxe == fe) && (((rx ^ flt) & m) == '0);
  endfunction

  function automatic void model_wr(logic [4:0] sel, logic [28:0] d);
    if (sel[4]) m_ind[sel[3:0]] = d;
    else case (sel)
      5'd0: m_glb = d;
      5'd1: m_ba = d;
      5'd2: m_bb = d;
      5'd3: m_fa = d;
      5'd4: m_fb = d;
      default: ;
    endcase
  endfunction

  // one cycle: optional write and optional compare together
  task automatic step(string req, logic wr, logic frz, logic [4:0] sel, logic [28:0] d,
                      logic cv, logic [28:0] rx, logic rxe, logic [28:0] flt, logic fe,
                      logic [3:0] idx, logic fifo, logic ind);
    logic e;
    @(negedge clk);
    mask_wr_i = wr; frozen_i = frz; mask_sel_i = sel; mask_wdata_i = d;
    cmp_valid_i = cv; rx_id_i = rx; rx_ext_i = rxe; flt_id_i = flt; flt_ext_i = fe;
    flt_idx_i = idx; fifo_mode_i = fifo; indiv_en_i = ind;
    e = exp_acc(rx, rxe, flt, fe, idx, fifo, ind);
    @(posedge clk); #1;
    if (wr && frz) model_wr(sel, d);
    check({req, " vld"}, accept_vld_o, cv);
    check({req, " acc"}, accept_o, cv & e);
    @(negedge clk);
    mask_wr_i = 0; cmp_valid_i = 0;
  endtask

  task automatic wr(logic [4:0] sel, logic [28:0] d, logic frz);
    step("wr", 1, frz, sel, d, 0, '0, 0, '0, 0, '0, 0, 0);
  endtask

  task automatic cmp(string req, logic [28:0] rx, logic rxe, logic [28:0] flt, logic fe,
                     logic [3:0] idx, logic fifo, logic ind);
    step(req, 0, 0, '0, '0, 1, rx, rxe, flt, fe, idx, fifo, ind);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp + 1, n_bad);
      $finish;
    end
  end

  initial begin
    logic [28:0] a, b, d;
    logic [3:0]  ix;
    foreach (m_ind[i]) m_ind[i] = '0;
    void'($urandom(32'd1234));
    #12;
    check("R1 acc", accept_o, 1'b0);
    check("R1 vld", accept_vld_o, 1'b0);
    rst_n = 1;
    // R1/R6: all masks zero after reset, anything with matching flag accepted
    cmp("R1", 29'h1ABCDEF0, 1, 29'h0123_4567, 1, 4'd3, 0, 0);
    cmp("R6", 29'h0000_0001, 0, 29'h1FFF_FFFF, 0, 4'd14, 0, 0);
    // R7: ext flag mismatch rejects even with zero mask
    cmp("R7", 29'h55, 1, 29'h55, 0, 4'd2, 0, 0);
    // R2/R5: global all ones
    wr(5'd0, '1, 1);
    cmp("R5", 29'h0ABC_1234, 1, 29'h0ABC_1235, 1, 4'd3, 0, 0);
    cmp("R5", 29'h0ABC_1234, 1, 29'h0ABC_1234, 1, 4'd3, 0, 0);
    cmp("R2", 29'h0ABC_1234, 1, 29'h0ABC_1235, 1, 4'd14, 0, 0);
    wr(5'd2, 29'h0000_0001, 1);
    cmp("R2", 29'h0ABC_1234, 1, 29'h0ABC_1235, 1, 4'd15, 0, 0);
    cmp("R2", 29'h0ABC_1234, 1, 29'h1ABC_1234, 1, 4'd15, 0, 0);
    // R3: fifo mode; 14 uses global, 6 uses FIFO mask A
    cmp("R3", 29'h0ABC_1234, 1, 29'h0ABC_1235, 1, 4'd14, 1, 0);
    cmp("R3", 29'h0ABC_1234, 1, 29'h0ABC_1235, 1, 4'd6, 1, 0);
    wr(5'd4, 29'h1000_0000, 1);
    cmp("R3", 29'h0ABC_1234, 1, 29'h1ABC_1234, 1, 4'd7, 1, 0);
    // R4: individual masks override global
    cmp("R4", 29'h0ABC_1234, 1, 29'h0ABC_1235, 1, 4'd3, 0, 1);
    wr(5'd19, 29'h0000_00F0, 1);
    cmp("R4", 29'h0ABC_1234, 1, 29'h0ABC_1244, 1, 4'd3, 1, 1);
    // R8: standard frame ignores low 18 bits
    cmp("R8", {11'h2A5, 18'h3FFFF}, 0, {11'h2A5, 18'h0}, 0, 4'd1, 0, 0);
    cmp("R8", {11'h2A5, 18'h0}, 0, {11'h2A4, 18'h0}, 0, 4'd1, 0, 0);
    // R9: unfrozen write dropped
    wr(5'd0, '0, 0);
    cmp("R9", 29'h0000_0000, 1, 29'h0000_0100, 1, 4'd5, 0, 0);
    // R10: idle cycle
    @(negedge clk); @(posedge clk); #1;
    check("R10 idle vld", accept_vld_o, 1'b0);
    check("R10 idle acc", accept_o, 1'b0);
    // R11: write and compare in same cycle use old mask
    step("R11", 1, 1, 5'd0, '0, 1, 29'h7, 1, 29'h6, 1, 4'd0, 0, 0);
    cmp("R11 after", 29'h7, 1, 29'h6, 1, 4'd0, 0, 0);
    step("R11", 1, 1, 5'd1, '1, 1, 29'h7, 1, 29'h6, 1, 4'd14, 0, 0);
    // random mix
    for (int i = 0; i < 400; i++) begin
      a = 29'($urandom);
      b = a ^ (29'(1) << ($urandom % 29)) ^ (($urandom % 3 == 0) ? 29'($urandom) : 29'(0));
      if ($urandom % 4 == 0) b = a;
      d = ($urandom % 3 == 0) ? 29'($urandom) & 29'($urandom) : 29'($urandom);
      ix = 4'($urandom);
      step(($urandom % 2) ? "R5 rnd" : "R11 rnd", ($urandom % 3) == 0, ($urandom % 4) != 0,
           ($urandom % 2) ? {1'b1, 4'($urandom)} : 5'($urandom % 5), d,
           ($urandom % 5) != 0, a, ($urandom % 4) != 0, b, ($urandom % 8) != 0 ? 1'b1 : 1'b0,
           ix, 1'($urandom), 1'($urandom));
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule